// File: doc/BRIEF.md
# Shift-Register Clock Divider Pair

This block divides a clock by a programmable integer without a binary counter. Each divider holds a linear feedback shift register that advances once per clock. When the register reaches its terminal state (all ones), the next edge loads it from a reload register and toggles the divided output. The reload register is written with a position in the shift sequence, not a binary count: to divide by N, software writes the state that lies N-1 steps before the terminal state. The output therefore changes level once every N clocks.

Two dividers share the clock and a synchronous reset: a 6-bit reference divider and an 8-bit feedback divider, each with its own write strobe and code input. The shared package also holds the sequence arithmetic: a forward step, a backward step, and a helper that turns an integer divisor into its reload code. Reset loads a chosen default divisor into each divider.

Top module: `lfsr_pll_dividers`

## Requirements
- R1: While `rst` is high at a clock edge, both outputs go low and each state register and reload register take the reset code for that divider's default divisor. After release, the first output toggle comes on the Nth edge for default divisor N (4 for the reference divider, 8 for the feedback divider).
- R2: In a non-terminal state the register shifts one place toward its top bit each clock. The bottom bit takes the XNOR of the tap bits. The all-zero state moves straight to the terminal all-ones state.
- R3: On the edge where the state is all ones, the state loads the reload register and the output inverts. With a reload code N-1 steps before the terminal state, consecutive output toggles are exactly N clocks apart.
- R4: The reference divider is 6 bits wide with taps on bits 5 and 4, and covers divisors 1 to 64. Divisor 1 uses code 0x3F, divisor 2 uses 0x00, and divisor 3 uses 0x20.
- R5: The feedback divider is 8 bits wide with taps on bits 7, 3, 2 and 1, and covers divisors 2 to 160. Divisor 2 uses code 0x00, divisor 3 uses 0x80, and divisor 4 uses 0xC0.
- R6: A write to a reload register does not disturb the period in progress. It is used first at the next terminal edge. A write captured on a terminal edge takes effect one period later.
- R7: The output changes only on terminal edges, so no period is shortened. When several writes fall within one period, the last one wins.
- R8: The package helper `div_to_code(w, n)` returns the reload code for divisor n at width w.
- R9: The two dividers are independent: writing one divider's code leaves the other divider's period unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that both dividers count |
| rst | input | 1 | Synchronous reset, active high |
| ref_wr_en | input | 1 | Strobe to write the reference reload register |
| ref_wr_code | input | REF_W | Sequence position for the reference divider |
| fb_wr_en | input | 1 | Strobe to write the feedback reload register |
| fb_wr_code | input | FB_W | Sequence position for the feedback divider |
| ref_clk_div | output | 1 | Reference divider output |
| fb_clk_div | output | 1 | Feedback divider output |

## Verification
The bench builds the block with its default widths of 6 and 8 bits and default divisors of 4 and 8. At these widths every supported divisor can be swept: all 64 reference codes and feedback codes up to 160 are measured as toggle spacing. The expected codes come from a distance table that the bench derives by walking the sequence forward from every state, so both ends of each chain are exercised, including the zero-to-terminal jump and the divide-by-one case. Directed cases place writes in the middle of a period, on a terminal edge, and twice within one period. Randomly drawn divisors then mix the two dividers.

// File: rtl/lfsr_div_pkg.sv
package lfsr_div_pkg;

  localparam int LFSR_MAX_W = 16;
  typedef logic [LFSR_MAX_W-1:0] lfsr_word_t;

  // All-ones terminal state for a register of width w.
  function automatic lfsr_word_t terminal_state(input int w);
    return lfsr_word_t'((32'd1 << w) - 32'd1);
  endfunction

  // Feedback taps, one maximal-length trinomial or pentanomial per width.
  function automatic lfsr_word_t tap_mask(input int w);
    case (w)
      3:       return lfsr_word_t'(16'h0006);
      4:       return lfsr_word_t'(16'h000C);
      5:       return lfsr_word_t'(16'h0014);
      6:       return lfsr_word_t'(16'h0030);
      7:       return lfsr_word_t'(16'h0060);
      default: return lfsr_word_t'(16'h008E);
    endcase
  endfunction

  // One clock of the sequence: shift up, XNOR of taps into bit 0,
  // all-zero jumps straight to the terminal state.
  function automatic lfsr_word_t step_fwd(input int w, input lfsr_word_t s);
    lfsr_word_t ones;
    ones = terminal_state(w);
    if (s == '0) return ones;
    return ((s << 1) | lfsr_word_t'(~^(s & tap_mask(w)))) & ones;
  endfunction

  // Inverse of step_fwd on the chain that ends at the terminal state.
  function automatic lfsr_word_t step_back(input int w, input lfsr_word_t s);
    lfsr_word_t ones;
    lfsr_word_t top;
    lfsr_word_t lo;
    logic       t;
    ones = terminal_state(w);
    top  = lfsr_word_t'(32'd1 << (w - 1));
    if (s == ones) return '0;
    lo = s >> 1;
    t  = ~s[0] ^ (^(lo & tap_mask(w) & ~top));
    return t ? (lo | top) : lo;
  endfunction

  // Reload code for divisor n: the state n-1 steps before the terminal.
  function automatic lfsr_word_t div_to_code(input int w, input int n);
    lfsr_word_t s;
    s = terminal_state(w);
    for (int i = 1; i < n; i++) s = step_back(w, s);
    return s;
  endfunction

endpackage

// File: rtl/lfsr_next.sv
module lfsr_next #(
  parameter int W = 6
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt
);
  import lfsr_div_pkg::*;

  lfsr_word_t wide_nxt;

  always_comb wide_nxt = step_fwd(W, lfsr_word_t'(cur));

  assign nxt = wide_nxt[W-1:0];

  logic unused_hi;
  assign unused_hi = ^wide_nxt[LFSR_MAX_W-1:W];

endmodule

// File: rtl/lfsr_div_core.sv
module lfsr_div_core #(
  parameter int           W          = 6,
  parameter logic [W-1:0] RESET_CODE = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_code,
  output logic         div_out,
  output logic         term,
  output logic [W-1:0] st,
  output logic [W-1:0] rl
);
  localparam logic [W-1:0] TERM_STATE = '1;

  logic [W-1:0] st_q;
  logic [W-1:0] rl_q;
  logic [W-1:0] st_step;
  logic         out_q;

  lfsr_next #(.W(W)) u_next (
    .cur (st_q),
    .nxt (st_step)
  );

  assign term = (st_q == TERM_STATE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= RESET_CODE;
      rl_q  <= RESET_CODE;
      out_q <= 1'b0;
    end else begin
      if (wr_en) rl_q <= wr_code;
      if (term) begin
        st_q  <= rl_q;
        out_q <= ~out_q;
      end else begin
        st_q  <= st_step;
      end
    end
  end

  assign div_out = out_q;
  assign st      = st_q;
  assign rl      = rl_q;

endmodule

// File: rtl/lfsr_pll_dividers.sv
module lfsr_pll_dividers #(
  parameter int REF_W       = 6,
  parameter int FB_W        = 8,
  parameter int REF_RST_DIV = 4,
  parameter int FB_RST_DIV  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_wr_en,
  input  logic [REF_W-1:0] ref_wr_code,
  input  logic             fb_wr_en,
  input  logic [FB_W-1:0]  fb_wr_code,
  output logic             ref_clk_div,
  output logic             fb_clk_div
);
  import lfsr_div_pkg::*;

  localparam lfsr_word_t REF_RST_WIDE = div_to_code(REF_W, REF_RST_DIV);
  localparam lfsr_word_t FB_RST_WIDE  = div_to_code(FB_W, FB_RST_DIV);
  localparam logic [REF_W-1:0] REF_RST_CODE = REF_RST_WIDE[REF_W-1:0];
  localparam logic [FB_W-1:0]  FB_RST_CODE  = FB_RST_WIDE[FB_W-1:0];

  // Internal events brought out for the bound checker.
  logic             ref_term;
  logic [REF_W-1:0] ref_st;
  logic [REF_W-1:0] ref_rl;
  logic             fb_term;
  logic [FB_W-1:0]  fb_st;
  logic [FB_W-1:0]  fb_rl;

  lfsr_div_core #(.W(REF_W), .RESET_CODE(REF_RST_CODE)) u_ref_div (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (ref_wr_en),
    .wr_code (ref_wr_code),
    .div_out (ref_clk_div),
    .term    (ref_term),
    .st      (ref_st),
    .rl      (ref_rl)
  );

  lfsr_div_core #(.W(FB_W), .RESET_CODE(FB_RST_CODE)) u_fb_div (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (fb_wr_en),
    .wr_code (fb_wr_code),
    .div_out (fb_clk_div),
    .term    (fb_term),
    .st      (fb_st),
    .rl      (fb_rl)
  );

endmodule

// File: rtl/lfsr_div_checker.sv
module lfsr_div_checker #(
  parameter int W = 6
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_en,
  input logic [W-1:0] wr_code,
  input logic         term,
  input logic [W-1:0] st,
  input logic [W-1:0] rl,
  input logic         div_out
);
  localparam logic [W-1:0] ONES = '1;

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (div_out == 1'b0 && st == rl));

  p_zero_jump_r2: assert property (@(posedge clk) disable iff (rst)
    (st == '0) |=> (st == ONES));

  p_toggle_on_term_r3: assert property (@(posedge clk) disable iff (rst)
    term |=> (div_out != $past(div_out)));

  p_reload_on_term_r3: assert property (@(posedge clk) disable iff (rst)
    term |=> (st == $past(rl)));

  p_no_back_to_back_r3: assert property (@(posedge clk) disable iff (rst)
    (term && rl != ONES) |=> !term);

  p_write_capture_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rl == $past(wr_code)));

  p_reload_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(rl));

  p_out_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !term |=> $stable(div_out));

endmodule

bind lfsr_pll_dividers lfsr_div_checker #(.W(REF_W)) u_chk_ref (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (ref_wr_en),
  .wr_code (ref_wr_code),
  .term    (ref_term),
  .st      (ref_st),
  .rl      (ref_rl),
  .div_out (ref_clk_div)
);

bind lfsr_pll_dividers lfsr_div_checker #(.W(FB_W)) u_chk_fb (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (fb_wr_en),
  .wr_code (fb_wr_code),
  .term    (fb_term),
  .st      (fb_st),
  .rl      (fb_rl),
  .div_out (fb_clk_div)
);

// File: tb/tb_lfsr_pll_dividers.sv
module tb_lfsr_pll_dividers;

  logic       clk = 1'b0;
  logic       rst;
  logic       ref_wr_en;
  logic [5:0] ref_wr_code;
  logic       fb_wr_en;
  logic [7:0] fb_wr_code;
  logic       ref_clk_div;
  logic       fb_clk_div;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  int ref_code [1:64];
  int fb_code  [1:256];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lfsr_pll_dividers dut (
    .clk         (clk),
    .rst         (rst),
    .ref_wr_en   (ref_wr_en),
    .ref_wr_code (ref_wr_code),
    .fb_wr_en    (fb_wr_en),
    .fb_wr_code  (fb_wr_code),
    .ref_clk_div (ref_clk_div),
    .fb_clk_div  (fb_clk_div)
  );

  // Bench model: count forward steps from a state to the terminal state.
  function automatic int steps_to_end(input int w, input int s0);
    int ones = (1 << w) - 1;
    int mask = (w == 6) ? 'h30 : 'h8E;
    int s = s0;
    int k = 0;
    while (s != ones && k < 1000) begin
      if (s == 0) s = ones;
      else s = ((s << 1) & ones) | ((($countones(s & mask) % 2) == 0) ? 1 : 0);
      k++;
    end
    return k;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic out_of(input bit fb);
    return fb ? fb_clk_div : ref_clk_div;
  endfunction

  task automatic wait_toggle(input bit fb, output int at);
    logic prev;
    prev = out_of(fb);
    forever begin
      @(negedge clk);
      if (out_of(fb) != prev) begin
        at = cyc;
        return;
      end
    end
  endtask

  task automatic wr(input bit fb, input int code);
    if (fb) begin fb_wr_en = 1'b1; fb_wr_code = 8'(code); end
    else    begin ref_wr_en = 1'b1; ref_wr_code = 6'(code); end
    @(negedge clk);
    ref_wr_en = 1'b0;
    fb_wr_en  = 1'b0;
  endtask

  // Program a code, let the old period finish, measure one new period.
  task automatic prog_meas(input bit fb, input int code, output int per, output int t_end);
    int t1;
    wr(fb, code);
    wait_toggle(fb, t1);
    wait_toggle(fb, t_end);
    per = t_end - t1;
  endtask

  initial begin
    int per, t_end, t1, t2, c0, mism, n;
    logic v0;
    rst = 1'b1;
    ref_wr_en = 1'b0; ref_wr_code = '0;
    fb_wr_en  = 1'b0; fb_wr_code  = '0;
    void'($urandom(32'd4711));

    for (int s = 0; s < 64; s++)  ref_code[steps_to_end(6, s) + 1] = s;
    for (int s = 0; s < 256; s++) fb_code[steps_to_end(8, s) + 1]  = s;

    // R4 / R5: stated codes fall out of the bench model
    chk("R4", "code div1", ref_code[1], 'h3F);
    chk("R4", "code div2", ref_code[2], 'h00);
    chk("R4", "code div3", ref_code[3], 'h20);
    chk("R5", "code div2", fb_code[2], 'h00);
    chk("R5", "code div3", fb_code[3], 'h80);
    chk("R5", "code div4", fb_code[4], 'hC0);

    // R8: package helper agrees with the bench table
    mism = 0;
    for (int d = 1; d <= 64; d++)
      if (int'(lfsr_div_pkg::div_to_code(6, d)) != ref_code[d]) mism++;
    chk("R8", "helper mismatches w6", mism, 0);
    mism = 0;
    for (int d = 2; d <= 160; d++)
      if (int'(lfsr_div_pkg::div_to_code(8, d)) != fb_code[d]) mism++;
    chk("R8", "helper mismatches w8", mism, 0);

    // R1: reset state and first toggle after release
    repeat (3) @(negedge clk);
    chk("R1", "ref out in reset", int'(ref_clk_div), 0);
    chk("R1", "fb out in reset", int'(fb_clk_div), 0);
    rst = 1'b0;
    c0 = cyc;
    wait_toggle(1'b0, t1);
    chk("R1", "ref first toggle", t1 - c0, 4);
    wait_toggle(1'b1, t2);
    chk("R1", "fb first toggle", t2 - c0, 8);

    // R2 / R3 / R4: every reference divisor
    for (int d = 1; d <= 64; d++) begin
      prog_meas(1'b0, ref_code[d], per, t_end);
      chk("R4", $sformatf("ref R2/R3 period div %0d", d), per, d);
    end

    // R2 / R3 / R5: every feedback divisor
    for (int d = 2; d <= 160; d++) begin
      prog_meas(1'b1, fb_code[d], per, t_end);
      chk("R5", $sformatf("fb R2/R3 period div %0d", d), per, d);
    end

    // R6: write in the middle of a period
    prog_meas(1'b0, ref_code[5], per, t_end);
    @(negedge clk);
    wr(1'b0, ref_code[9]);
    wait_toggle(1'b0, t1);
    chk("R6", "mid write keeps old period", t1 - t_end, 5);
    wait_toggle(1'b0, t2);
    chk("R6", "mid write new period", t2 - t1, 9);

    // R6: write captured on the terminal edge
    prog_meas(1'b0, ref_code[6], per, t_end);
    v0 = ref_clk_div;
    repeat (5) @(negedge clk);
    wr(1'b0, ref_code[11]);
    chk("R6", "terminal edge toggled", int'(ref_clk_div != v0), 1);
    wait_toggle(1'b0, t1);
    chk("R6", "term write one more old period", t1 - (t_end + 6), 6);
    wait_toggle(1'b0, t2);
    chk("R6", "term write new period", t2 - t1, 11);

    // R7: last of two writes in one period wins
    prog_meas(1'b0, ref_code[8], per, t_end);
    wr(1'b0, ref_code[7]);
    wr(1'b0, ref_code[3]);
    wait_toggle(1'b0, t1);
    chk("R7", "old period intact", t1 - t_end, 8);
    wait_toggle(1'b0, t2);
    chk("R7", "last write wins", t2 - t1, 3);

    // R9: feedback write leaves reference period alone
    prog_meas(1'b0, ref_code[7], per, t_end);
    wr(1'b1, fb_code[50]);
    wait_toggle(1'b0, t1);
    wait_toggle(1'b0, t2);
    chk("R9", "ref period after fb write", t2 - t1, 7);
    prog_meas(1'b1, fb_code[12], per, t_end);
    wr(1'b0, ref_code[33]);
    wait_toggle(1'b1, t1);
    wait_toggle(1'b1, t2);
    chk("R9", "fb period after ref write", t2 - t1, 12);

    // R3: random divisors on both dividers
    for (int i = 0; i < 12; i++) begin
      n = int'($urandom_range(64, 1));
      prog_meas(1'b0, ref_code[n], per, t_end);
      chk("R3", $sformatf("random ref div %0d", n), per, n);
      n = int'($urandom_range(160, 2));
      prog_meas(1'b1, fb_code[n], per, t_end);
      chk("R3", $sformatf("random fb div %0d", n), per, n);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule